// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit single-precision binary floating-point values over several clock cycles. A one-cycle `start` pulse captures both operands and the operation select. The block then steps through a fixed sequence of stages: line up the exponents, combine the significands, normalize, and round. The encoded result comes back with a one-cycle `done` pulse.

Each operand has a sign in bit 31, an 8-bit exponent biased by 127 in bits 30..23, and a 23-bit fraction in bits 22..0. A normal value equals (-1)^sign × 1.fraction × 2^(exponent-127). Infinities, NaNs and zeros are recognised on entry and resolved in one cycle. Subnormal inputs are treated as zero. The datapath carries two extra bits below the significand, a guard bit and a round bit. It rounds by adding one at the last kept bit whenever the guard bit is set. Results outside the exponent range saturate to infinity or flush to zero, and a flag reports each case.

Top module: `fp_add_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `done`, `result`, `ovf`, `unf` and `inv` are all zero until the first operation completes.
- R2: For finite normal operands, `result` is a + b when `sub`=0 and a - b when `sub`=1. Subtraction flips bit 31 of b before anything else. Example: 3.0 - 5.0 = 0xC0000000.
- R3: The operand with the smaller magnitude is shifted right by the exponent difference inside a 26-bit frame: 24 significand bits, then guard, then round. Any bit shifted below the round bit is lost. Example: 1.0 + 2^-24 gives 0x3F800001, and 1.0 + 2^-25 gives 0x3F800000.
- R4: When the guard bit is 1, one is added at the last kept bit. If that addition carries out of the significand, the value is shifted right once and the exponent goes up by one. Example: 0x3FFFFFFF + 0x33800000 = 0x40000000.
- R5: A sum that needs a left shift is normalized by the leading-zero count in a single stage. An exact zero sum returns +0 (0x00000000).
- R6: A final biased exponent of 255 or more returns ±infinity (0x7F800000 with the result sign) and raises `ovf`.
- R7: A final biased exponent of 0 or less returns ±zero and raises `unf`.
- R8: A NaN on either input, or the sum of two infinities with opposite effective signs, returns 0x7FC00000 and raises `inv`.
- R9: An infinite operand, if R8 does not apply, is passed through with its effective sign. A zero or subnormal operand (exponent field 0) counts as zero and returns the other operand. Two zeros give a sign bit equal to the AND of both effective signs.
- R10: `done` is high for exactly one cycle. It comes 1 clock after `start` is sampled when a special case applies, and 5 clocks after it otherwise. A `start` that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only when idle |
| sub | input | 1 | 1 selects a - b, 0 selects a + b |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| done | output | 1 | One-cycle pulse when `result` and the flags are updated |
| result | output | 32 | Rounded single-precision result, held until the next `done` |
| ovf | output | 1 | Exponent overflow on the last result |
| unf | output | 1 | Exponent underflow on the last result |
| inv | output | 1 | Invalid operation on the last result |

## Verification
The assertions rely on reset being held low from time zero. Before the first edge after reset, the output registers are therefore defined. The assertions also rely on the operands and `sub` mattering only at the edge where an idle block samples `start`. The stimulus drives every input at the falling clock edge and holds it until the next one. It pulses `start` only while the block is idle, except in the single directed test that checks a start during a running operation is ignored. The bench reads results only in cycles where `done` is high. The assertions cover the flag-to-encoding relations and the single-cycle `done` pulse.

// File: rtl/fp_add_seq.sv
module fp_add_seq #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    sub,
  input  logic [EXP_W+FRAC_W:0]   a,
  input  logic [EXP_W+FRAC_W:0]   b,
  output logic                    done,
  output logic [EXP_W+FRAC_W:0]   result,
  output logic                    ovf,
  output logic                    unf,
  output logic                    inv
);
  localparam int W    = EXP_W + FRAC_W + 1;
  localparam int SW   = FRAC_W + 1;
  localparam int FW   = SW + 2;
  localparam int LZW  = $clog2(FW);
  localparam int XW   = EXP_W + 2;
  localparam logic [EXP_W-1:0] EMAX = '1;
  localparam logic [W-1:0] QNAN = {1'b0, EMAX, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [2:0] {IDLE, ALIGN, ADD, NORM, ROUND} state_t;
  state_t st;

  logic             sgn, op_sub, zsum;
  logic [EXP_W-1:0] dif;
  logic signed [XW-1:0] xp;
  logic [FW-1:0]    big_m, sml_m;
  logic [FW:0]      sig;

  wire [EXP_W-1:0]  ea = a[W-2:FRAC_W];
  wire [EXP_W-1:0]  eb = b[W-2:FRAC_W];
  wire              sa = a[W-1];
  wire              sb = b[W-1] ^ sub;
  wire a_zero = (ea == '0);
  wire b_zero = (eb == '0);
  wire a_inf  = (ea == EMAX) && (a[FRAC_W-1:0] == '0);
  wire b_inf  = (eb == EMAX) && (b[FRAC_W-1:0] == '0);
  wire a_nan  = (ea == EMAX) && (a[FRAC_W-1:0] != '0);
  wire b_nan  = (eb == EMAX) && (b[FRAC_W-1:0] != '0);
  wire bad    = a_nan | b_nan | (a_inf & b_inf & (sa != sb));
  wire special = a_nan | b_nan | a_inf | b_inf | a_zero | b_zero;
  wire a_big  = a[W-2:0] >= b[W-2:0];

  logic [W-1:0] spec_res;
  always_comb begin
    if (bad)         spec_res = QNAN;
    else if (a_inf)  spec_res = {sa, a[W-2:0]};
    else if (b_inf)  spec_res = {sb, b[W-2:0]};
    else if (a_zero && b_zero) spec_res = {sa & sb, {(W-1){1'b0}}};
    else if (a_zero) spec_res = {sb, b[W-2:0]};
    else             spec_res = {sa, a[W-2:0]};
  end

  logic [LZW-1:0] lz;
  always_comb begin
    lz = '0;
    for (int i = 0; i < FW; i++)
      if (sig[i]) lz = LZW'(FW - 1 - i);
  end

  logic [SW:0] rnd;
  logic signed [XW-1:0] xf;
  logic [FRAC_W-1:0] frac_f;
  always_comb begin
    rnd = {1'b0, sig[FW-1:2]} + {{SW{1'b0}}, sig[1]};
    if (rnd[SW]) begin
      frac_f = rnd[SW-1:1];
      xf = xp + XW'(1);
    end else begin
      frac_f = rnd[FRAC_W-1:0];
      xf = xp;
    end
  end
  wire fin_ovf = !zsum && (xf >= $signed(XW'(EMAX)));
  wire fin_unf = !zsum && (xf <= $signed(XW'(0)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; done <= 1'b0; result <= '0;
      ovf <= 1'b0; unf <= 1'b0; inv <= 1'b0;
      sgn <= 1'b0; op_sub <= 1'b0; zsum <= 1'b0;
      dif <= '0; xp <= '0; big_m <= '0; sml_m <= '0; sig <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          if (special) begin
            result <= spec_res; inv <= bad;
            ovf <= 1'b0; unf <= 1'b0; done <= 1'b1;
          end else begin
            op_sub <= sa ^ sb;
            if (a_big) begin
              sgn <= sa; xp <= XW'(ea); dif <= ea - eb;
              big_m <= {1'b1, a[FRAC_W-1:0], 2'b00};
              sml_m <= {1'b1, b[FRAC_W-1:0], 2'b00};
            end else begin
              sgn <= sb; xp <= XW'(eb); dif <= eb - ea;
              big_m <= {1'b1, b[FRAC_W-1:0], 2'b00};
              sml_m <= {1'b1, a[FRAC_W-1:0], 2'b00};
            end
            st <= ALIGN;
          end
        end
        ALIGN: begin
          sml_m <= (dif >= EXP_W'(FW)) ? '0 : sml_m >> dif;
          st <= ADD;
        end
        ADD: begin
          sig <= op_sub ? {1'b0, big_m} - {1'b0, sml_m} : {1'b0, big_m} + {1'b0, sml_m};
          st <= NORM;
        end
        NORM: begin
          zsum <= (sig == '0);
          if (sig[FW]) begin
            sig <= sig >> 1;
            xp  <= xp + XW'(1);
          end else if (sig != '0) begin
            sig <= sig << lz;
            xp  <= xp - XW'(lz);
          end
          st <= ROUND;
        end
        ROUND: begin
          done <= 1'b1; inv <= 1'b0;
          ovf <= fin_ovf; unf <= fin_unf;
          if (zsum)         result <= '0;
          else if (fin_ovf) result <= {sgn, EMAX, {FRAC_W{1'b0}}};
          else if (fin_unf) result <= {sgn, {(W-1){1'b0}}};
          else              result <= {sgn, xf[EXP_W-1:0], frac_f};
          st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_busy_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ALIGN) |=> !done);
  a_r8_inv_qnan: assert property (@(posedge clk) disable iff (!rst_n)
    inv |-> (result == QNAN));
  a_r6_ovf_inf: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (result[W-2:0] == {EMAX, {FRAC_W{1'b0}}}));
  a_r7_unf_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> (result[W-2:0] == '0));
  a_r6_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ovf, unf, inv}) <= 1);
  a_r5_norm_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ROUND && !zsum) |-> sig[FW-1]);
endmodule

// File: tb/fp_add_seq_test.sv
module fp_add_seq_test;
  logic clk = 0, rst_n = 0, start = 0, sub = 0;
  logic [31:0] a = 0, b = 0;
  logic done, ovf, unf, inv;
  logic [31:0] result;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  fp_add_seq uut (.clk(clk), .rst_n(rst_n), .start(start), .sub(sub), .a(a), .b(b),
                  .done(done), .result(result), .ovf(ovf), .unf(unf), .inv(inv));

  // {sub, a, b, expected result, expected {ovf,unf,inv}, expected latency}
  localparam int NV = 18;
  localparam logic [103:0] VEC [NV] = '{
    {1'b0, 32'h3F800000, 32'h3F800000, 32'h40000000, 3'b000, 4'd5}, // R2 1+1
    {1'b0, 32'h3FC00000, 32'h40200000, 32'h40800000, 3'b000, 4'd5}, // R2 1.5+2.5
    {1'b1, 32'h40400000, 32'h40A00000, 32'hC0000000, 3'b000, 4'd5}, // R2 3-5
    {1'b0, 32'hBF800000, 32'hBF800000, 32'hC0000000, 3'b000, 4'd5}, // R2 -1+-1
    {1'b0, 32'h3F800000, 32'h33800000, 32'h3F800001, 3'b000, 4'd5}, // R3 guard set
    {1'b0, 32'h3F800000, 32'h33000000, 32'h3F800000, 3'b000, 4'd5}, // R3 round only
    {1'b0, 32'h3FFFFFFF, 32'h33800000, 32'h40000000, 3'b000, 4'd5}, // R4 carry
    {1'b1, 32'h3F800000, 32'h3F7FFFFF, 32'h33800000, 3'b000, 4'd5}, // R5 cancel
    {1'b1, 32'h3F800000, 32'h3F800000, 32'h00000000, 3'b000, 4'd5}, // R5 exact zero
    {1'b0, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 3'b100, 4'd5}, // R6 overflow
    {1'b1, 32'h00800000, 32'h00C00000, 32'h80000000, 3'b010, 4'd5}, // R7 underflow
    {1'b0, 32'h7F800000, 32'hFF800000, 32'h7FC00000, 3'b001, 4'd1}, // R8 inf-inf
    {1'b0, 32'h7FC00001, 32'h3F800000, 32'h7FC00000, 3'b001, 4'd1}, // R8 NaN
    {1'b0, 32'h7F800000, 32'h3F800000, 32'h7F800000, 3'b000, 4'd1}, // R9 inf pass
    {1'b1, 32'h3F800000, 32'h7F800000, 32'hFF800000, 3'b000, 4'd1}, // R9 1-inf
    {1'b0, 32'h00000000, 32'hC0400000, 32'hC0400000, 3'b000, 4'd1}, // R9 zero
    {1'b0, 32'h00000001, 32'h3F800000, 32'h3F800000, 3'b000, 4'd1}, // R9 subnormal
    {1'b0, 32'h80000000, 32'h80000000, 32'h80000000, 3'b000, 4'd1}  // R9 -0+-0
  };

  int lat;
  task automatic run(input logic s, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    sub = s; a = x; b = y; start = 1;
    @(negedge clk);
    start = 0; lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10: watchdog expired actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {27'd0, done, ovf, unf, inv, |result}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", {27'd0, done, ovf, unf, inv, |result}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][103], VEC[i][102:71], VEC[i][70:39]);
      check($sformatf("R%0s vector %0d result", "x", i), result, VEC[i][38:7]);
      check($sformatf("R6/R7/R8 flags vector %0d", i), {29'd0, ovf, unf, inv}, {29'd0, VEC[i][6:4]});
      check($sformatf("R10 latency vector %0d", i), 32'(lat), {28'd0, VEC[i][3:0]});
      @(negedge clk);
      check("R10 done single cycle", {31'd0, done}, 32'd0);
    end

    // R10: start during an operation is ignored
    @(negedge clk);
    sub = 0; a = 32'h3F800000; b = 32'h3F800000; start = 1;
    @(negedge clk);
    a = 32'h40400000; b = 32'h40400000;
    @(negedge clk);
    start = 0; lat = 2;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R10 busy start ignored result", result, 32'h40000000);
    check("R10 busy start latency", 32'(lat), 32'd5);
    repeat (8) begin
      @(negedge clk);
      if (done) check("R10 no extra done", 32'd1, 32'd0);
    end
    check("R10 result held", result, 32'h40000000);

    // R2 subtraction flips sign of b: -2 - (-3) = 1
    run(1'b1, 32'hC0000000, 32'hC0400000);
    check("R2 neg minus neg", result, 32'h3F800000);
    // R6 overflow with negative sign
    run(1'b0, 32'hFF7FFFFF, 32'hFF7FFFFF);
    check("R6 negative overflow", {result[31:1], ovf}, {31'h7FC00000, 1'b1});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule